// File: doc/BRIEF.md
# Frame-Addressed Bidirectional Port Controller

This block acts on the payload of a bus frame that has already been received and found to address this node. A three-bit local address selects one of eight actions: load the control register, return a status byte, write port A, port B or both ports together, or read back port A, port B or both. Write frames carry from one to six bytes, and the byte count decides how much port state a frame replaces. A frame whose count does not fit its action, or whose option byte is not zero, is refused as a whole and leaves every register as it was.

Each of the two 8-bit ports keeps a level register and a direction register and drives its pins through per-pin output enables. Read frames sample the live pin levels, so an input pin reports what the outside world drives and an output pin reports its own drive. A safety-entry strobe from the line supervisor releases every pin of port A to high impedance and leaves port B alone. The caller presents one frame per `frame_vld` cycle and gets an acknowledge or a refusal pulse, plus read data when the frame was a read, one clock later.

Top module: `port_frame_ctrl`

## Requirements
- R1: The local address decodes as 0 control write, 1 status read, 2 port A write, 3 port A read, 4 dual write, 5 dual read, 6 port B write, 7 port B read. Bit 0 set means read. Every accepted frame gives `ack`, every refused frame gives `rej`.
- R2: A control write is accepted only with exactly one byte, and that byte (byte 0) goes to `ctrl_q`. Any other count is refused and `ctrl_q` keeps its value.
- R3: A single-port write (address 2 or 6) is accepted only with 1, 2 or 3 bytes. Counts 0 and 4 to 7 are refused and change no port register.
- R4: A one-byte single-port write loads byte 0 as the port level and turns all eight pins of that port into outputs.
- R5: A two- or three-byte single-port write loads byte 0 as the level and byte 1 as the direction. Direction bit 1 drives the pin and direction bit 0 leaves it undriven.
- R6: A three-byte single-port write whose byte 2 (the option byte) is not zero is refused and changes nothing.
- R7: A dual write is accepted only with 6 bytes, in the order level A, direction A, option A, level B, direction B, option B (bytes 0 to 5), and only when both option bytes are zero. Otherwise it is refused and changes nothing.
- R8: A read is always accepted, pulses `rd_vld` and changes no register. `rd_data` carries the live pin levels: port A or B in bits 7:0 with bits 15:8 zero, a dual read with A in 7:0 and B in 15:8, and a status read with `stat_in` in 7:0.
- R9: After reset both ports are high impedance, the level registers and `ctrl_q` are zero, and no response is pending.
- R10: A `safe_enter` pulse clears every direction bit of port A and leaves port B untouched. If a frame writes port A in the same cycle, its level byte is still taken and its direction is still forced to zero.
- R11: `ack`, `rej` and `rd_vld` are one-cycle pulses in the cycle after the `frame_vld` cycle. `ack` and `rej` are never high together.
- R12: A pin whose direction bit is 0 is never driven, whatever its level bit. This covers the forbidden level-1 input case, which behaves as a plain input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| frame_vld | input | 1 | One-cycle strobe: a frame for this node is presented |
| loc_addr | input | 3 | Local address field of the frame |
| byte_cnt | input | CNT_W | Number of data bytes the frame carries |
| frame_bytes | input | 48 | Data bytes, byte k in bits 8k+7:8k |
| safe_enter | input | 1 | Strobe: the node enters safety mode |
| stat_in | input | 8 | Status byte returned by a status read |
| pin_in_a | input | 8 | Sensed levels of port A pins |
| pin_in_b | input | 8 | Sensed levels of port B pins |
| ack | output | 1 | Frame accepted (one-cycle pulse) |
| rej | output | 1 | Frame refused (one-cycle pulse) |
| rd_vld | output | 1 | Read data valid (one-cycle pulse) |
| rd_data | output | 16 | Read-back bytes |
| ctrl_q | output | 8 | Control register |
| pa_out | output | 8 | Port A drive levels |
| pa_oe | output | 8 | Port A output enables |
| pb_out | output | 8 | Port B drive levels |
| pb_oe | output | 8 | Port B output enables |

## Verification
The assertions watch every cycle for invariants of the response and register paths. Responses must be mutually exclusive and must follow a frame strobe. A read must come with an acknowledge. A dual write is only acknowledged with six bytes. The control register only moves after a one-byte control write. A port register only changes on a write or a safety strobe, and port A is high impedance right after that strobe. Whether the right bytes land in the right register, how the count selects level-only or level-and-direction loading, and whether read-back reflects live pins mixed with external drive can only be shown by the bench. Its sweep over every address, every count and zero and non-zero option bytes is compared against a reference model, with the safety and forbidden-pattern cases run on top.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  localparam int PORT_W      = 8;
  localparam int FRAME_BYTES = 6;
  localparam int FRAME_W     = FRAME_BYTES * PORT_W;
  localparam int RD_W        = 2 * PORT_W;

  typedef enum logic [2:0] {
    ACT_WR_CTRL = 3'd0,
    ACT_RD_STAT = 3'd1,
    ACT_WR_A    = 3'd2,
    ACT_RD_A    = 3'd3,
    ACT_WR_AB   = 3'd4,
    ACT_RD_AB   = 3'd5,
    ACT_WR_B    = 3'd6,
    ACT_RD_B    = 3'd7
  } act_e;

  typedef struct packed {
    logic              we;
    logic [PORT_W-1:0] lvl;
    logic [PORT_W-1:0] dir;
  } port_wr_t;
endpackage

// File: rtl/fpc_decode.sv
module fpc_decode
  import fpc_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic               frame_vld,
  input  logic [2:0]         loc_addr,
  input  logic [CNT_W-1:0]   byte_cnt,
  input  logic [FRAME_W-1:0] frame_bytes,
  output logic               accept,
  output logic               reject,
  output logic               is_read,
  output act_e               act,
  output port_wr_t           wr_a,
  output port_wr_t           wr_b,
  output logic               ctrl_we,
  output logic [PORT_W-1:0]  ctrl_wd
);
  logic [PORT_W-1:0] byt [FRAME_BYTES];
  logic cnt_one, single_ok, opt_clear, dual_ok, ok;
  port_wr_t single;

  always_comb begin
    for (int k = 0; k < FRAME_BYTES; k++) begin
      byt[k] = frame_bytes[k*PORT_W +: PORT_W];
    end
  end

  always_comb begin
    act       = act_e'(loc_addr);
    is_read   = loc_addr[0];
    cnt_one   = (byte_cnt == CNT_W'(1));
    single_ok = (byte_cnt >= CNT_W'(1)) && (byte_cnt <= CNT_W'(3));
    opt_clear = (byte_cnt != CNT_W'(3)) || (byt[2] == '0);
    dual_ok   = (byte_cnt == CNT_W'(6)) && (byt[2] == '0) && (byt[5] == '0);

    unique case (act)
      ACT_WR_CTRL:        ok = cnt_one;
      ACT_WR_A, ACT_WR_B: ok = single_ok && opt_clear;
      ACT_WR_AB:          ok = dual_ok;
      default:            ok = 1'b1;
    endcase

    accept = frame_vld && ok;
    reject = frame_vld && !ok;

    single.we  = 1'b0;
    single.lvl = byt[0];
    single.dir = cnt_one ? '1 : byt[1];

    wr_a    = single;
    wr_b    = single;
    wr_a.we = accept && (act == ACT_WR_A);
    wr_b.we = accept && (act == ACT_WR_B);
    if (act == ACT_WR_AB) begin
      wr_a.we  = accept;
      wr_a.lvl = byt[0];
      wr_a.dir = byt[1];
      wr_b.we  = accept;
      wr_b.lvl = byt[3];
      wr_b.dir = byt[4];
    end

    ctrl_we = accept && (act == ACT_WR_CTRL);
    ctrl_wd = byt[0];
  end
endmodule

// File: rtl/fpc_port_bank.sv
module fpc_port_bank
  import fpc_pkg::*;
#(
  parameter bit CLR_ON_SAFE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  port_wr_t          wr,
  input  logic              safe_enter,
  output logic [PORT_W-1:0] lvl_q,
  output logic [PORT_W-1:0] dir_q
);
  logic [PORT_W-1:0] lvl_n, dir_n;
  logic              lvl_en, dir_en;
  logic              safe_clr;

  generate
    if (CLR_ON_SAFE) begin : g_safe
      assign safe_clr = safe_enter;
    end else begin : g_nosafe
      assign safe_clr = 1'b0;
    end
  endgenerate

  always_comb begin
    lvl_en = wr.we;
    dir_en = wr.we || safe_clr;
    lvl_n  = wr.lvl;
    dir_n  = safe_clr ? '0 : wr.dir;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      dir_q <= '0;
    end else begin
      if (lvl_en) lvl_q <= lvl_n;
      if (dir_en) dir_q <= dir_n;
    end
  end

  generate
    if (CLR_ON_SAFE) begin : g_chk_safe
      a_r10_safe_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        safe_enter |=> (dir_q == '0));
      a_r3_hold_a: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr.we && !safe_enter) |=> ($stable(lvl_q) && $stable(dir_q)));
    end else begin : g_chk_plain
      a_r10_hold_b: assert property (@(posedge clk) disable iff (!rst_n)
        !wr.we |=> ($stable(lvl_q) && $stable(dir_q)));
    end
  endgenerate
endmodule

// File: rtl/fpc_resp.sv
module fpc_resp
  import fpc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              reject,
  input  logic              is_read,
  input  act_e              act,
  input  logic [PORT_W-1:0] pin_a,
  input  logic [PORT_W-1:0] pin_b,
  input  logic [PORT_W-1:0] stat,
  output logic              ack,
  output logic              rej,
  output logic              rd_vld,
  output logic [RD_W-1:0]   rd_data
);
  logic [RD_W-1:0] rd_n;
  logic            rd_en;

  always_comb begin
    rd_en = accept && is_read;
    unique case (act)
      ACT_RD_STAT: rd_n = {{PORT_W{1'b0}}, stat};
      ACT_RD_A:    rd_n = {{PORT_W{1'b0}}, pin_a};
      ACT_RD_B:    rd_n = {{PORT_W{1'b0}}, pin_b};
      ACT_RD_AB:   rd_n = {pin_b, pin_a};
      default:     rd_n = rd_data;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack     <= 1'b0;
      rej     <= 1'b0;
      rd_vld  <= 1'b0;
      rd_data <= '0;
    end else begin
      ack    <= accept;
      rej    <= reject;
      rd_vld <= rd_en;
      if (rd_en) rd_data <= rd_n;
    end
  end

  a_r11_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack && rej));
  a_r8_read_acked: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vld |-> ack);
endmodule

// File: rtl/port_frame_ctrl.sv
module port_frame_ctrl
  import fpc_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_vld,
  input  logic [2:0]         loc_addr,
  input  logic [CNT_W-1:0]   byte_cnt,
  input  logic [FRAME_W-1:0] frame_bytes,
  input  logic               safe_enter,
  input  logic [PORT_W-1:0]  stat_in,
  input  logic [PORT_W-1:0]  pin_in_a,
  input  logic [PORT_W-1:0]  pin_in_b,
  output logic               ack,
  output logic               rej,
  output logic               rd_vld,
  output logic [RD_W-1:0]    rd_data,
  output logic [PORT_W-1:0]  ctrl_q,
  output logic [PORT_W-1:0]  pa_out,
  output logic [PORT_W-1:0]  pa_oe,
  output logic [PORT_W-1:0]  pb_out,
  output logic [PORT_W-1:0]  pb_oe
);
  localparam int NPORT = 2;

  logic              accept, reject, is_read, ctrl_we;
  act_e              act;
  port_wr_t          wr_a, wr_b;
  port_wr_t          wr_v  [NPORT];
  logic [PORT_W-1:0] lvl_v [NPORT];
  logic [PORT_W-1:0] dir_v [NPORT];
  logic [PORT_W-1:0] ctrl_wd, ctrl_n;

  fpc_decode #(.CNT_W(CNT_W)) u_dec (
    .frame_vld   (frame_vld),
    .loc_addr    (loc_addr),
    .byte_cnt    (byte_cnt),
    .frame_bytes (frame_bytes),
    .accept      (accept),
    .reject      (reject),
    .is_read     (is_read),
    .act         (act),
    .wr_a        (wr_a),
    .wr_b        (wr_b),
    .ctrl_we     (ctrl_we),
    .ctrl_wd     (ctrl_wd)
  );

  assign wr_v[0] = wr_a;
  assign wr_v[1] = wr_b;

  generate
    for (genvar p = 0; p < NPORT; p++) begin : g_port
      fpc_port_bank #(.CLR_ON_SAFE(p == 0)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (wr_v[p]),
        .safe_enter (safe_enter),
        .lvl_q      (lvl_v[p]),
        .dir_q      (dir_v[p])
      );
    end
  endgenerate

  assign pa_out = lvl_v[0];
  assign pa_oe  = dir_v[0];
  assign pb_out = lvl_v[1];
  assign pb_oe  = dir_v[1];

  always_comb ctrl_n = ctrl_wd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= ctrl_n;
  end

  fpc_resp u_resp (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept),
    .reject  (reject),
    .is_read (is_read),
    .act     (act),
    .pin_a   (pin_in_a),
    .pin_b   (pin_in_b),
    .stat    (stat_in),
    .ack     (ack),
    .rej     (rej),
    .rd_vld  (rd_vld),
    .rd_data (rd_data)
  );

  a_r11_follows_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (ack || rej) |-> $past(frame_vld));
  a_r7_dual_six: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && $past(loc_addr) == 3'd4) |-> ($past(byte_cnt) == CNT_W'(6)));
  a_r2_ctrl_source: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q != $past(ctrl_q)) |->
      ($past(frame_vld) && $past(loc_addr) == 3'd0 && $past(byte_cnt) == CNT_W'(1)));
endmodule

// File: tb/port_frame_ctrl_test.sv
`timescale 1ns/1ps
module port_frame_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        frame_vld, safe_enter;
  logic [2:0]  loc_addr, byte_cnt;
  logic [47:0] frame_bytes;
  logic [7:0]  stat_in, ext_a, ext_b;
  logic [7:0]  pin_in_a, pin_in_b;
  logic        ack, rej, rd_vld;
  logic [15:0] rd_data;
  logic [7:0]  ctrl_q, pa_out, pa_oe, pb_out, pb_oe;

  int n_tests = 0;
  int n_fail  = 0;

  logic [7:0] m_lvl [2];
  logic [7:0] m_dir [2];
  logic [7:0] m_ctrl;

  always #2.5 clk = ~clk;

  assign pin_in_a = (pa_oe & pa_out) | (~pa_oe & ext_a);
  assign pin_in_b = (pb_oe & pb_out) | (~pb_oe & ext_b);

  port_frame_ctrl uut (
    .clk(clk), .rst_n(rst_n), .frame_vld(frame_vld), .loc_addr(loc_addr),
    .byte_cnt(byte_cnt), .frame_bytes(frame_bytes), .safe_enter(safe_enter),
    .stat_in(stat_in), .pin_in_a(pin_in_a), .pin_in_b(pin_in_b),
    .ack(ack), .rej(rej), .rd_vld(rd_vld), .rd_data(rd_data), .ctrl_q(ctrl_q),
    .pa_out(pa_out), .pa_oe(pa_oe), .pb_out(pb_out), .pb_oe(pb_oe)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act_v, input logic [31:0] exp_v);
    n_tests++;
    if (act_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act_v, exp_v);
    end
  endtask

  function automatic bit exp_ok(input int a, input int c, input logic [47:0] by);
    case (a)
      0:       return c == 1;
      2, 6:    return (c >= 1) && (c <= 3) && ((c != 3) || (by[23:16] == 8'h00));
      4:       return (c == 6) && (by[23:16] == 8'h00) && (by[47:40] == 8'h00);
      default: return 1'b1;
    endcase
  endfunction

  function automatic string reg_tag(input int a, input int c, input logic [47:0] by);
    if (a == 0) return "R2";
    if (a == 4) return "R7";
    if (a[0]) return "R8";
    if (c == 3 && by[23:16] != 8'h00) return "R6";
    if (c < 1 || c > 3) return "R3";
    if (c == 1) return "R4";
    return "R5";
  endfunction

  task automatic check_state(input string tag);
    chk(tag, "pa_out", {24'h0, pa_out}, {24'h0, m_lvl[0]});
    chk(tag, "pa_oe",  {24'h0, pa_oe},  {24'h0, m_dir[0]});
    chk(tag, "pb_out", {24'h0, pb_out}, {24'h0, m_lvl[1]});
    chk(tag, "pb_oe",  {24'h0, pb_oe},  {24'h0, m_dir[1]});
    chk(tag, "ctrl_q", {24'h0, ctrl_q}, {24'h0, m_ctrl});
  endtask

  task automatic do_frame(input bit vld, input int a, input int c,
                          input logic [47:0] by, input bit safe, input string tag);
    bit          ok;
    logic [15:0] exp_rd;
    @(negedge clk);
    frame_vld   = vld;
    loc_addr    = 3'(a);
    byte_cnt    = 3'(c);
    frame_bytes = by;
    safe_enter  = safe;
    ok = vld && exp_ok(a, c, by);
    case (a)
      1:       exp_rd = {8'h00, stat_in};
      3:       exp_rd = {8'h00, pin_in_a};
      5:       exp_rd = {pin_in_b, pin_in_a};
      7:       exp_rd = {8'h00, pin_in_b};
      default: exp_rd = 16'h0;
    endcase
    if (ok) begin
      case (a)
        0: m_ctrl = by[7:0];
        2, 6: begin
          m_lvl[a / 4] = by[7:0];
          m_dir[a / 4] = (c == 1) ? 8'hFF : by[15:8];
        end
        4: begin
          m_lvl[0] = by[7:0];   m_dir[0] = by[15:8];
          m_lvl[1] = by[31:24]; m_dir[1] = by[39:32];
        end
        default: ;
      endcase
    end
    if (safe) m_dir[0] = 8'h00;
    @(negedge clk);
    frame_vld  = 1'b0;
    safe_enter = 1'b0;
    chk("R1", "ack", {31'h0, ack}, {31'h0, ok});
    chk("R1", "rej", {31'h0, rej}, {31'h0, vld && !ok});
    chk("R8", "rd_vld", {31'h0, rd_vld}, {31'h0, ok && a[0]});
    if (ok && a[0]) chk("R8", "rd_data", {16'h0, rd_data}, {16'h0, exp_rd});
    check_state(tag);
    @(negedge clk);
    chk("R11", "pulse end", {29'h0, ack, rej, rd_vld}, 32'h0);
  endtask

  task automatic finish_up;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    rst_n = 1'b0; frame_vld = 1'b0; safe_enter = 1'b0;
    loc_addr = '0; byte_cnt = '0; frame_bytes = '0;
    stat_in = 8'h6D; ext_a = 8'h00; ext_b = 8'h00;
    m_lvl[0] = 8'h00; m_lvl[1] = 8'h00; m_dir[0] = 8'h00; m_dir[1] = 8'h00; m_ctrl = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    check_state("R9");
    chk("R9", "resp", {29'h0, ack, rej, rd_vld}, 32'h0);

    // Sweep: every address and count, option bytes zero then non-zero
    for (int pass = 0; pass < 2; pass++) begin
      for (int a = 0; a < 8; a++) begin
        for (int c = 0; c < 8; c++) begin
          logic [47:0] by;
          for (int k = 0; k < 6; k++)
            by[8*k +: 8] = 8'h5A ^ 8'(k * 29) ^ 8'(a << 4) ^ 8'(c) ^ 8'(pass * 77);
          if (pass == 0) begin
            by[23:16] = 8'h00; by[47:40] = 8'h00;
          end else begin
            by[23:16] = by[23:16] | 8'h01; by[47:40] = by[47:40] | 8'h10;
          end
          ext_a = 8'(a * 37 + c * 5 + pass);
          ext_b = ~8'(a * 11 + c * 19);
          do_frame(1'b1, a, c, by, 1'b0, reg_tag(a, c, by));
        end
      end
    end

    // R12: direction 0 with level 1 stays undriven; pins follow the outside
    ext_a = 8'h00;
    do_frame(1'b1, 2, 2, 48'h0000_0000_0FFF, 1'b0, "R12");
    chk("R12", "pa_oe", {24'h0, pa_oe}, 32'h0F);
    do_frame(1'b1, 3, 0, 48'h0, 1'b0, "R12");
    chk("R12", "read A", {16'h0, rd_data}, 32'h000F);
    ext_a = 8'hA0;
    do_frame(1'b1, 3, 0, 48'h0, 1'b0, "R12");
    chk("R12", "read A ext", {16'h0, rd_data}, 32'h00AF);

    // R10: safety entry releases port A only
    do_frame(1'b1, 4, 6, 48'h00F0_3C00_FFA5, 1'b0, "R7");
    do_frame(1'b0, 0, 0, 48'h0, 1'b1, "R10");
    chk("R10", "pa_oe", {24'h0, pa_oe}, 32'h00);
    chk("R10", "pa_out", {24'h0, pa_out}, 32'hA5);
    chk("R10", "pb_oe", {24'h0, pb_oe}, 32'hF0);
    chk("R10", "pb_out", {24'h0, pb_out}, 32'h3C);
    // R10: safety strobe together with a port A write
    do_frame(1'b1, 2, 3, 48'h0000_0000_FF77, 1'b1, "R10");
    chk("R10", "pa_oe same cycle", {24'h0, pa_oe}, 32'h00);
    chk("R10", "pa_out same cycle", {24'h0, pa_out}, 32'h77);
    // R10: safety strobe together with a port B write leaves B's write intact
    do_frame(1'b1, 6, 1, 48'h0000_0000_0099, 1'b1, "R10");
    chk("R10", "pb_oe", {24'h0, pb_oe}, 32'hFF);

    // R2: control write with two bytes refused, then one byte accepted
    do_frame(1'b1, 0, 2, 48'h0000_0000_1234, 1'b0, "R2");
    do_frame(1'b1, 0, 1, 48'h0000_0000_00C3, 1'b0, "R2");
    chk("R2", "ctrl", {24'h0, ctrl_q}, 32'hC3);

    finish_up();
  end
endmodule